// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block produces data-memory addresses for a signal-processing datapath. It holds four pointer slots. Each slot has an index, a length and a base value, and the block also holds four modify values that any slot may use. On an access request the block returns the chosen pointer as the address. It then adds the chosen modify value to the pointer, so the pointer is post-modified.

When the slot's length is nonzero, the updated pointer is folded back into the window that starts at the slot's base. This lets a pointer walk a circular buffer in either direction. A per-access bit-reverse flag mirrors the bits of the returned address, which is the ordering an FFT needs. The stored pointer is always updated in natural order, whether or not the flag is set.

A chip that needs two operand addresses in one cycle places two instances of this block side by side. Memory arrays and instruction decoding live outside the block.

Top module: `circ_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, every index, modify, length and base register is 0, `addr_o` is 0 and `addr_vld_o` is 0.
- R2: When `acc_en` is high at a clock edge, `addr_o` holds the selected pointer's value from before that edge after the edge, and `addr_vld_o` is 1. When `acc_en` is low at an edge, `addr_vld_o` is 0 after it.
- R3: With length 0 the pointer becomes (pointer + modify) modulo 2^14. The modify value is signed two's complement, 14 bits wide.
- R4: `acc_mod` chooses which of the four modify registers is added. It is independent of `acc_ptr`.
- R5: With length L nonzero and base B, an updated value at or above B+L is reduced by L.
- R6: With length L nonzero and base B, an updated value below B is increased by L. A pointer inside [B, B+L-1] moved by a modify of magnitude at most L stays inside that window.
- R7: With `acc_brev` high, bit k of `addr_o` equals bit 13-k of the pointer. The pointer update is the same as without the flag.
- R8: When a write to an index register and an access to the same pointer happen at the same edge, the written value is stored and the post-modify result is discarded. The address output for that access is still the old pointer.
- R9: `wr_sel` encodes the target register: 0 index, 1 modify, 2 length, 3 base. `wr_idx` selects the slot. A write changes only that one register.
- R10: With neither `acc_en` nor `wr_en` high, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register kind: 0 index, 1 modify, 2 length, 3 base |
| wr_idx | input | 2 | Slot number for the write |
| wr_data | input | 14 | Value to write |
| acc_en | input | 1 | Access request |
| acc_ptr | input | 2 | Pointer slot used for the access |
| acc_mod | input | 2 | Modify register used for the post-update |
| acc_brev | input | 1 | Return the address bit-reversed |
| addr_o | output | 14 | Registered address |
| addr_vld_o | output | 1 | Address valid, one cycle per access |

## Verification
The bound checker examines every cycle. It checks that each access yields a valid address equal to the prior pointer, reversed when asked. It checks that idle cycles hold all pointers, and that an index write always lands with the written value. It also checks that a pointer starting inside its window stays there after a bounded modify. The exact wrap arithmetic at both window edges is shown only by the bench's scenarios. So are the modulo-2^14 rollover in linear mode, the choice among the modify registers, the isolation of a base write from its index, and the return to zeroed state after a mid-run reset.

// File: rtl/dag_pkg.sv
package dag_pkg;
    localparam int unsigned ADDR_W_DEF = 14;
    localparam int unsigned NPTR_DEF   = 4;

    typedef enum logic [1:0] {
        SEL_INDEX  = 2'd0,
        SEL_MODIFY = 2'd1,
        SEL_LENGTH = 2'd2,
        SEL_BASE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dag_regfile.sv
module dag_regfile
    import dag_pkg::*;
#(
    parameter int unsigned AW   = ADDR_W_DEF,
    parameter int unsigned NPTR = NPTR_DEF,
    localparam int unsigned PW  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_sel,
    input  logic [PW-1:0]            wr_idx,
    input  logic [AW-1:0]            wr_data,
    input  logic                     upd_en,
    input  logic [PW-1:0]            upd_idx,
    input  logic [AW-1:0]            upd_val,
    output logic [NPTR-1:0][AW-1:0]  idx_all,
    output logic [NPTR-1:0][AW-1:0]  mdf_all,
    output logic [NPTR-1:0][AW-1:0]  len_all,
    output logic [NPTR-1:0][AW-1:0]  bas_all
);
    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] idx;
        logic [NPTR-1:0][AW-1:0] mdf;
        logic [NPTR-1:0][AW-1:0] len;
        logic [NPTR-1:0][AW-1:0] bas;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        // post-modify first, so a write to the same index overrides it
        if (upd_en) begin
            rf_d.idx[upd_idx] = upd_val;
        end
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_INDEX:  rf_d.idx[wr_idx] = wr_data;
                SEL_MODIFY: rf_d.mdf[wr_idx] = wr_data;
                SEL_LENGTH: rf_d.len[wr_idx] = wr_data;
                SEL_BASE:   rf_d.bas[wr_idx] = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign idx_all = rf_q.idx;
    assign mdf_all = rf_q.mdf;
    assign len_all = rf_q.len;
    assign bas_all = rf_q.bas;
endmodule

// File: rtl/dag_wrap.sv
module dag_wrap #(
    parameter int unsigned AW = 14,
    localparam int unsigned XW = AW + 2
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] mdf,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] bas,
    output logic [AW-1:0] nxt
);
    logic signed [XW-1:0] sum_x;
    logic signed [XW-1:0] off_x;
    logic signed [XW-1:0] len_x;
    logic signed [XW-1:0] fix_x;

    always_comb begin
        sum_x = $signed({2'b00, ptr}) + $signed({{2{mdf[AW-1]}}, mdf});
        off_x = sum_x - $signed({2'b00, bas});
        len_x = $signed({2'b00, len});
        fix_x = sum_x;
        if (len != '0) begin
            if (off_x < 0) begin
                fix_x = sum_x + len_x;
            end else if (off_x >= len_x) begin
                fix_x = sum_x - len_x;
            end
        end
        nxt = fix_x[AW-1:0];
    end
endmodule

// File: rtl/dag_bitrev.sv
module dag_bitrev #(
    parameter int unsigned AW = 14
) (
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    for (genvar k = 0; k < AW; k++) begin : g_rev
        assign dout[k] = din[AW-1-k];
    end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import dag_pkg::*;
#(
    parameter int unsigned AW   = ADDR_W_DEF,
    parameter int unsigned NPTR = NPTR_DEF,
    localparam int unsigned PW  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [PW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          acc_en,
    input  logic [PW-1:0] acc_ptr,
    input  logic [PW-1:0] acc_mod,
    input  logic          acc_brev,
    output logic [AW-1:0] addr_o,
    output logic          addr_vld_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic          vld;
    } out_t;

    logic [NPTR-1:0][AW-1:0] idx_all;
    logic [NPTR-1:0][AW-1:0] mdf_all;
    logic [NPTR-1:0][AW-1:0] len_all;
    logic [NPTR-1:0][AW-1:0] bas_all;

    logic [AW-1:0] cur_ptr;
    logic [AW-1:0] cur_rev;
    logic [AW-1:0] nxt_ptr;

    out_t out_d, out_q;

    dag_regfile #(.AW(AW), .NPTR(NPTR)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (acc_en),
        .upd_idx (acc_ptr),
        .upd_val (nxt_ptr),
        .idx_all (idx_all),
        .mdf_all (mdf_all),
        .len_all (len_all),
        .bas_all (bas_all)
    );

    assign cur_ptr = idx_all[acc_ptr];

    dag_wrap #(.AW(AW)) u_wrap (
        .ptr (cur_ptr),
        .mdf (mdf_all[acc_mod]),
        .len (len_all[acc_ptr]),
        .bas (bas_all[acc_ptr]),
        .nxt (nxt_ptr)
    );

    dag_bitrev #(.AW(AW)) u_rev (
        .din  (cur_ptr),
        .dout (cur_rev)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = acc_en;
        if (acc_en) begin
            out_d.addr = acc_brev ? cur_rev : cur_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_o     = out_q.addr;
    assign addr_vld_o = out_q.vld;
endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
    parameter int unsigned AW   = 14,
    parameter int unsigned NPTR = 4,
    localparam int unsigned PW  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [1:0]              wr_sel,
    input logic [PW-1:0]           wr_idx,
    input logic [AW-1:0]           wr_data,
    input logic                    acc_en,
    input logic [PW-1:0]           acc_ptr,
    input logic [PW-1:0]           acc_mod,
    input logic                    acc_brev,
    input logic [AW-1:0]           addr_o,
    input logic                    addr_vld_o,
    input logic [NPTR-1:0][AW-1:0] idx_all,
    input logic [NPTR-1:0][AW-1:0] mdf_all,
    input logic [NPTR-1:0][AW-1:0] len_all,
    input logic [NPTR-1:0][AW-1:0] bas_all
);
    function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int k = 0; k < AW; k++) r[k] = v[AW-1-k];
        return r;
    endfunction

    logic [AW-1:0] p_c, m_c, l_c, b_c, mag_c;
    logic          in_win_c;
    logic [AW-1:0] p_q, b_q, l_q;
    logic [PW-1:0] sel_q;

    always_comb begin
        p_c   = idx_all[acc_ptr];
        m_c   = mdf_all[acc_mod];
        l_c   = len_all[acc_ptr];
        b_c   = bas_all[acc_ptr];
        mag_c = m_c[AW-1] ? (~m_c + 1'b1) : m_c;
        in_win_c = acc_en && (l_c != '0) && (p_c >= b_c)
                && ({1'b0, p_c} < ({1'b0, b_c} + {1'b0, l_c}))
                && (({1'b0, b_c} + {1'b0, l_c}) <= (AW+1)'(2**AW))
                && (mag_c <= l_c)
                && !(wr_en && wr_idx == acc_ptr);
    end

    always_ff @(posedge clk) begin
        p_q   <= p_c;
        b_q   <= b_c;
        l_q   <= l_c;
        sel_q <= acc_ptr;
    end

    p_vld_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> addr_vld_o);

    p_no_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !addr_vld_o);

    p_addr_old_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_brev) |=> (addr_o == p_q));

    p_addr_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_brev) |=> (addr_o == mirror(p_q)));

    p_stay_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_win_c |=> ((idx_all[sel_q] >= b_q)
                      && ({1'b0, idx_all[sel_q]} < ({1'b0, b_q} + {1'b0, l_q}))));

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !wr_en) |=> $stable(idx_all) && $stable(mdf_all)
                                && $stable(len_all) && $stable(bas_all));

    p_index_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (idx_all[$past(wr_idx)] == $past(wr_data)));
endmodule

bind circ_addr_gen circ_addr_gen_chk #(.AW(AW), .NPTR(NPTR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .acc_en     (acc_en),
    .acc_ptr    (acc_ptr),
    .acc_mod    (acc_mod),
    .acc_brev   (acc_brev),
    .addr_o     (addr_o),
    .addr_vld_o (addr_vld_o),
    .idx_all    (idx_all),
    .mdf_all    (mdf_all),
    .len_all    (len_all),
    .bas_all    (bas_all)
);

// File: tb/tb_circ_addr_gen.sv
module tb_circ_addr_gen;
    localparam int CLK_P = 10;
    localparam int NV    = 26;

    // row: [33] access, [32:31] sel|ptr, [30:29] slot|mod, [28] brev, [27:14] data, [13:0] expected
    localparam logic [33:0] TBL [NV] = '{
        {1'b0, 2'd0, 2'd0, 1'b0, 14'h0010, 14'h0000},   // I0 = 0x10
        {1'b0, 2'd1, 2'd0, 1'b0, 14'h0003, 14'h0000},   // M0 = 3
        {1'b0, 2'd1, 2'd1, 1'b0, 14'h3FFE, 14'h0000},   // M1 = -2
        {1'b1, 2'd0, 2'd0, 1'b0, 14'h0000, 14'h0010},   // R3 linear
        {1'b1, 2'd0, 2'd0, 1'b0, 14'h0000, 14'h0013},
        {1'b1, 2'd0, 2'd1, 1'b0, 14'h0000, 14'h0016},   // R4 other modify
        {1'b1, 2'd0, 2'd1, 1'b0, 14'h0000, 14'h0014},
        {1'b0, 2'd3, 2'd1, 1'b0, 14'h0100, 14'h0000},   // B1 = 0x100
        {1'b0, 2'd2, 2'd1, 1'b0, 14'h0005, 14'h0000},   // L1 = 5
        {1'b0, 2'd0, 2'd1, 1'b0, 14'h0103, 14'h0000},   // I1 = 0x103
        {1'b0, 2'd1, 2'd2, 1'b0, 14'h0003, 14'h0000},   // M2 = 3
        {1'b0, 2'd1, 2'd3, 1'b0, 14'h3FFC, 14'h0000},   // M3 = -4
        {1'b1, 2'd1, 2'd2, 1'b0, 14'h0000, 14'h0103},   // R5 upper wrap next
        {1'b1, 2'd1, 2'd2, 1'b0, 14'h0000, 14'h0101},
        {1'b1, 2'd1, 2'd2, 1'b0, 14'h0000, 14'h0104},
        {1'b1, 2'd1, 2'd2, 1'b0, 14'h0000, 14'h0102},
        {1'b1, 2'd1, 2'd3, 1'b0, 14'h0000, 14'h0100},   // R6 lower wrap next
        {1'b1, 2'd1, 2'd3, 1'b0, 14'h0000, 14'h0101},
        {1'b1, 2'd1, 2'd2, 1'b0, 14'h0000, 14'h0102},
        {1'b0, 2'd0, 2'd2, 1'b0, 14'h0001, 14'h0000},   // I2 = 1
        {1'b1, 2'd2, 2'd0, 1'b1, 14'h0000, 14'h2000},   // R7 mirrored
        {1'b1, 2'd2, 2'd0, 1'b1, 14'h0000, 14'h0800},
        {1'b1, 2'd2, 2'd0, 1'b0, 14'h0000, 14'h0007},   // R7 natural update
        {1'b0, 2'd0, 2'd3, 1'b0, 14'h3FFF, 14'h0000},   // I3 = 0x3FFF
        {1'b1, 2'd3, 2'd0, 1'b0, 14'h0000, 14'h3FFF},   // R3 rollover
        {1'b1, 2'd3, 2'd0, 1'b0, 14'h0000, 14'h0002}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, acc_en, acc_brev;
    logic [1:0]  wr_sel, wr_idx, acc_ptr, acc_mod;
    logic [13:0] wr_data;
    logic [13:0] addr_o;
    logic        addr_vld_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    circ_addr_gen dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod), .acc_brev(acc_brev),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o)
    );

    task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic quiet();
        wr_en = 0; acc_en = 0; acc_brev = 0;
        wr_sel = 0; wr_idx = 0; acc_ptr = 0; acc_mod = 0; wr_data = 0;
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic step(input logic we, input logic [1:0] ws, input logic [1:0] wi,
                        input logic [13:0] wd, input logic ae, input logic [1:0] ap,
                        input logic [1:0] am, input logic ab);
        wr_en = we; wr_sel = ws; wr_idx = wi; wr_data = wd;
        acc_en = ae; acc_ptr = ap; acc_mod = am; acc_brev = ab;
        @(negedge clk);
        quiet();
    endtask

    task automatic access(input logic [1:0] ap, input logic [1:0] am,
                          input string req, input logic [13:0] exp);
        step(0, 0, 0, 0, 1, ap, am, 0);
        chk(req, addr_o, exp);
        chk(req, {13'd0, addr_vld_o}, 14'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        quiet();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 addr in reset", addr_o, 14'h0000);
        chk("R1 vld in reset", {13'd0, addr_vld_o}, 14'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 vld after reset", {13'd0, addr_vld_o}, 14'd0);

        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = TBL[i];
            if (v[33]) begin
                step(0, 0, 0, 0, 1, v[32:31], v[30:29], v[28]);
                chk($sformatf("row %0d (R2 R3 R4 R5 R6 R7) addr", i), addr_o, v[13:0]);
                chk($sformatf("row %0d R2 valid", i), {13'd0, addr_vld_o}, 14'd1);
            end else begin
                step(1, v[32:31], v[30:29], v[27:14], 0, 0, 0, 0);
                chk($sformatf("row %0d R2 no valid on write", i), {13'd0, addr_vld_o}, 14'd0);
            end
        end

        // R10: idle cycles leave pointers and output state alone; p1 is at 0x100
        repeat (3) @(negedge clk);
        chk("R2 valid drops when idle", {13'd0, addr_vld_o}, 14'd0);
        access(2'd1, 2'd2, "R10 pointer held over idle", 14'h0100);

        // R8: index write and access on the same pointer; p0 is at 0x12
        step(1, 2'd0, 2'd0, 14'h0200, 1, 2'd0, 2'd0, 0);
        chk("R8 old pointer returned", addr_o, 14'h0012);
        access(2'd0, 2'd0, "R8 written value kept", 14'h0200);

        // R9: a base write leaves the index of that slot alone; p3 is at 0x0002+3
        step(1, 2'd3, 2'd3, 14'h3000, 0, 0, 0, 0);
        access(2'd3, 2'd0, "R9 index untouched by base write", 14'h0005);

        // R1: reset in the middle of a run clears every register
        rst_n = 0;
        @(negedge clk);
        chk("R1 vld cleared by reset", {13'd0, addr_vld_o}, 14'd0);
        rst_n = 1;
        access(2'd1, 2'd2, "R1 pointer cleared", 14'h0000);
        access(2'd1, 2'd2, "R1 modify cleared", 14'h0000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule